// File: doc/BRIEF.md
# Flash Embedded-Operation Toggle Status Generator

This block produces the two toggle status bits that a NOR flash returns while an internal program or erase is running. It tracks the device operation phase: idle, programming, erase selection time-out, erasing, erase suspended, programming while suspended, and a protected-target abort. It also keeps a bitmap of the sectors chosen for erasure. Software polls by issuing reads. A device-wide bit inverts on every read while an operation is busy. A sector bit inverts only when the read lands in a sector selected for erasure. Comparing the two bits tells the host both the mode (active or suspended) and the location (selected sector or not).

The command decoder upstream sends one-cycle completion pulses. Each pulse marks the final write of a command sequence. A single read strobe stands in for one read cycle, whatever marks it externally: an output-enable or chip-enable strobe in asynchronous mode, or an address-valid rising edge or a clock edge with address-valid low in synchronous mode. A microsecond tick times the dummy toggling that happens when an operation targets only protected sectors. Reads that carry no status are flagged as array reads.

Top module: `flash_toggle_status`

## Requirements
- R1: While programming, in the erase selection time-out, while erasing, while programming under suspend, and during an abort, every read strobe inverts `devToggle` and is flagged as status (`rdIsStatus`=1). As a result, two back-to-back reads return different values.
- R2: Once an operation completes (program done or erase done), `devToggle` holds its value on later reads, and every read in idle returns `rdIsStatus`=0.
- R3: While erase is suspended, `devToggle` holds across reads. After resume, it inverts again on each read.
- R4: In the time-out, erasing, suspended and suspend-program phases, `secToggle` inverts on a read only when the read sector is in the selection bitmap; otherwise it holds. While suspended, a read of a selected sector returns `rdIsStatus`=1 and a read of an unselected sector returns `rdIsStatus`=0.
- R5: If every selected sector is protected when erase begins, the block enters the abort phase for `ERASE_ABORT_TICKS` microsecond ticks (default 100), with reads returning toggling status. After the last tick, reads return `rdIsStatus`=0.
- R6: If only some selected sectors are protected, erase proceeds. The protected sectors are dropped from the selection, so reads to them do not invert `secToggle`.
- R7: A program command to a protected sector from idle enters the abort phase for `PROG_ABORT_TICKS` ticks (default 1) and then returns to idle.
- R8: A program command while suspended makes `devToggle` invert on reads until program done, then returns to the suspended behaviour. If that program targets a protected sector, it is ignored.
- R9: After reset, all outputs are 0. Both toggle bits are cleared to 0 when an operation starts from idle (a program command or the first erase selection).
- R10: The selection bitmap is emptied when an erase completes or an erase aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdSector | input | SEC_AW | Sector targeted by the program or erase-select pulse |
| progIssue | input | 1 | Program command sequence completed |
| progDone | input | 1 | Internal program finished |
| eraseSelect | input | 1 | Add `cmdSector` to the erase selection |
| eraseBegin | input | 1 | Selection time-out elapsed, erase starts |
| eraseDone | input | 1 | Internal erase finished |
| suspendReq | input | 1 | Suspend the running erase |
| resumeReq | input | 1 | Resume a suspended erase |
| sectorProt | input | NUM_SECT | Per-sector protect flags |
| usTick | input | 1 | One-cycle pulse every microsecond |
| readStrobe | input | 1 | One read cycle |
| readSector | input | SEC_AW | Sector addressed by the read |
| rdValid | output | 1 | Read result valid (one cycle after the strobe) |
| rdIsStatus | output | 1 | Read returns status rather than array data |
| devToggle | output | 1 | Device-level toggle bit |
| secToggle | output | 1 | Sector-level toggle bit |

## Verification
The assertions assume that a read strobe never falls in the same cycle as a command pulse, so that an operation start, which clears both toggle bits, is never mixed with a toggle. They also assume that both sector inputs stay below `NUM_SECT` and that the abort tick counts are at least 1. Command pulses that arrive in a phase where they mean nothing are legal, and the block ignores them. The stimulus drives every command pulse and every read in its own cycle. It uses only sector numbers inside the array and counts microsecond ticks one by one, so it stays within these assumptions.

// File: rtl/flash_tgl_pkg.sv
package flash_tgl_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_ERWAIT, OP_ERASING, OP_SUSP, OP_SUSPPROG, OP_ABORT
  } opState_t;

  typedef struct packed {
    logic opStart;    // clear both toggle bits
    logic devTog;     // invert device bit on this read
    logic secEn;      // sector bit may invert if the read hits the selection
    logic bmAdd;      // add cmdSector to the selection
    logic bmMask;     // drop protected sectors from the selection
    logic bmClear;    // empty the selection
    logic statusAll;  // this read returns status
    logic statusSel;  // this read returns status only on a selected sector
  } dpStrobe_t;
endpackage

// File: rtl/flash_tgl_ctrl.sv
module flash_tgl_ctrl
  import flash_tgl_pkg::*;
#(
  parameter int NUM_SECT          = 8,
  parameter int SEC_AW            = $clog2(NUM_SECT),
  parameter int PROG_ABORT_TICKS  = 1,
  parameter int ERASE_ABORT_TICKS = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEC_AW-1:0]   cmdSector,
  input  logic                progIssue,
  input  logic                progDone,
  input  logic                eraseSelect,
  input  logic                eraseBegin,
  input  logic                eraseDone,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic [NUM_SECT-1:0] sectorProt,
  input  logic                usTick,
  input  logic                readStrobe,
  input  logic                liveEmpty,
  output dpStrobe_t           stb
);
  localparam int MAXT  = (PROG_ABORT_TICKS > ERASE_ABORT_TICKS) ? PROG_ABORT_TICKS : ERASE_ABORT_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  opState_t   opState, opNext;
  logic [CNT_W-1:0] abortCnt, loadVal;
  logic       loadCnt;
  logic       cmdProt;

  assign cmdProt = sectorProt[cmdSector];

  always_comb begin
    opNext  = opState;
    loadCnt = 1'b0;
    loadVal = '0;
    stb     = '0;
    case (opState)
      OP_IDLE: begin
        if (progIssue) begin
          stb.opStart = 1'b1;
          if (cmdProt) begin
            opNext  = OP_ABORT;
            loadCnt = 1'b1;
            loadVal = CNT_W'(PROG_ABORT_TICKS);
          end else begin
            opNext = OP_PROG;
          end
        end else if (eraseSelect) begin
          stb.opStart = 1'b1;
          stb.bmAdd   = 1'b1;
          opNext      = OP_ERWAIT;
        end
      end
      OP_PROG: if (progDone) opNext = OP_IDLE;
      OP_ERWAIT: begin
        if (eraseSelect) stb.bmAdd = 1'b1;
        if (eraseBegin) begin
          if (liveEmpty) begin
            opNext      = OP_ABORT;
            loadCnt     = 1'b1;
            loadVal     = CNT_W'(ERASE_ABORT_TICKS);
            stb.bmClear = 1'b1;
          end else begin
            stb.bmMask = 1'b1;
            opNext     = OP_ERASING;
          end
        end
      end
      OP_ERASING: begin
        if (eraseDone) begin
          opNext      = OP_IDLE;
          stb.bmClear = 1'b1;
        end else if (suspendReq) begin
          opNext = OP_SUSP;
        end
      end
      OP_SUSP: begin
        if (resumeReq) opNext = OP_ERASING;
        else if (progIssue && !cmdProt) opNext = OP_SUSPPROG;
      end
      OP_SUSPPROG: if (progDone) opNext = OP_SUSP;
      OP_ABORT: if (usTick && abortCnt == CNT_W'(1)) opNext = OP_IDLE;
      default: opNext = OP_IDLE;
    endcase

    if (readStrobe) begin
      case (opState)
        OP_PROG, OP_ABORT: begin
          stb.devTog    = 1'b1;
          stb.statusAll = 1'b1;
        end
        OP_ERWAIT, OP_ERASING, OP_SUSPPROG: begin
          stb.devTog    = 1'b1;
          stb.statusAll = 1'b1;
          stb.secEn     = 1'b1;
        end
        OP_SUSP: begin
          stb.secEn     = 1'b1;
          stb.statusSel = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState  <= OP_IDLE;
      abortCnt <= '0;
    end else begin
      opState <= opNext;
      if (loadCnt) abortCnt <= loadVal;
      else if (opState == OP_ABORT && usTick && abortCnt != '0) abortCnt <= abortCnt - 1'b1;
    end
  end

  // R5 / R7: the abort phase always has ticks left to count
  assert_abort_cnt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ABORT) |-> (abortCnt != '0));

  // R7: the abort phase is left only on a tick
  assert_abort_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ABORT && !usTick) |=> (opState == OP_ABORT));

  // R3: a suspended erase gives no device toggle
  assert_susp_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_SUSP) |-> !stb.devTog);
endmodule

// File: rtl/flash_tgl_dpath.sv
module flash_tgl_dpath
  import flash_tgl_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int SEC_AW   = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [SEC_AW-1:0]   cmdSector,
  input  logic [SEC_AW-1:0]   readSector,
  input  logic                readStrobe,
  input  logic [NUM_SECT-1:0] sectorProt,
  output logic                liveEmpty,
  output logic                rdValid,
  output logic                rdIsStatus,
  output logic                devToggle,
  output logic                secToggle
);
  logic [NUM_SECT-1:0] selMap;
  logic                secHit;

  assign secHit    = selMap[readSector];
  assign liveEmpty = ~|(selMap & ~sectorProt);

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                              selMap[i] <= 1'b0;
      else if (stb.bmClear)                                   selMap[i] <= 1'b0;
      else if (stb.bmMask && sectorProt[i])                   selMap[i] <= 1'b0;
      else if (stb.bmAdd && cmdSector == SEC_AW'(i))          selMap[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devToggle  <= 1'b0;
      secToggle  <= 1'b0;
      rdValid    <= 1'b0;
      rdIsStatus <= 1'b0;
    end else begin
      if (stb.opStart) begin
        devToggle <= 1'b0;
        secToggle <= 1'b0;
      end else begin
        if (stb.devTog)            devToggle <= ~devToggle;
        if (stb.secEn && secHit)   secToggle <= ~secToggle;
      end
      rdValid    <= readStrobe;
      rdIsStatus <= readStrobe && (stb.statusAll || (stb.statusSel && secHit));
    end
  end

  // R1: a device toggle request flips the bit
  assert_dev_flip_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.devTog && !stb.opStart) |=> (devToggle != $past(devToggle)));

  // R2 / R3: without a request the device bit holds
  assert_dev_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.devTog && !stb.opStart) |=> $stable(devToggle));

  // R4: the sector bit moves only on a hit in an eligible phase
  assert_sec_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(stb.secEn && secHit) && !stb.opStart) |=> $stable(secToggle));

  // R9: operation start leaves both bits at 0
  assert_start_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.opStart |=> (!devToggle && !secToggle));

  // R10: clearing empties the selection
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.bmClear |=> (selMap == '0));

  // R1: a result appears only after a read strobe
  assert_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(readStrobe));
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
  import flash_tgl_pkg::*;
#(
  parameter int NUM_SECT          = 8,
  parameter int SEC_AW            = $clog2(NUM_SECT),
  parameter int PROG_ABORT_TICKS  = 1,
  parameter int ERASE_ABORT_TICKS = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEC_AW-1:0]   cmdSector,
  input  logic                progIssue,
  input  logic                progDone,
  input  logic                eraseSelect,
  input  logic                eraseBegin,
  input  logic                eraseDone,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic [NUM_SECT-1:0] sectorProt,
  input  logic                usTick,
  input  logic                readStrobe,
  input  logic [SEC_AW-1:0]   readSector,
  output logic                rdValid,
  output logic                rdIsStatus,
  output logic                devToggle,
  output logic                secToggle
);
  dpStrobe_t stb;
  logic      liveEmpty;

  flash_tgl_ctrl #(
    .NUM_SECT(NUM_SECT), .SEC_AW(SEC_AW),
    .PROG_ABORT_TICKS(PROG_ABORT_TICKS), .ERASE_ABORT_TICKS(ERASE_ABORT_TICKS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdSector(cmdSector),
    .progIssue(progIssue), .progDone(progDone), .eraseSelect(eraseSelect),
    .eraseBegin(eraseBegin), .eraseDone(eraseDone), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .sectorProt(sectorProt), .usTick(usTick),
    .readStrobe(readStrobe), .liveEmpty(liveEmpty), .stb(stb)
  );

  flash_tgl_dpath #(.NUM_SECT(NUM_SECT), .SEC_AW(SEC_AW)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdSector(cmdSector),
    .readSector(readSector), .readStrobe(readStrobe), .sectorProt(sectorProt),
    .liveEmpty(liveEmpty), .rdValid(rdValid), .rdIsStatus(rdIsStatus),
    .devToggle(devToggle), .secToggle(secToggle)
  );
endmodule

// File: tb/test_flash_toggle_status.sv
module test_flash_toggle_status;
  localparam int NS = 8, AW = 3, PT = 1, ET = 100;
  localparam int M_IDLE = 0, M_PROG = 1, M_WAIT = 2, M_ERS = 3, M_SUSP = 4, M_SPROG = 5, M_ABORT = 6;
  localparam int K_PROG = 0, K_SEL = 1, K_BEGIN = 2, K_EDONE = 3, K_PDONE = 4,
                 K_SUSP = 5, K_RES = 6, K_TICK = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic [AW-1:0] cmdSector = '0, readSector = '0;
  logic progIssue = 0, progDone = 0, eraseSelect = 0, eraseBegin = 0, eraseDone = 0;
  logic suspendReq = 0, resumeReq = 0, usTick = 0, readStrobe = 0;
  logic [NS-1:0] sectorProt = 8'b1000_0001;
  logic rdValid, rdIsStatus, devToggle, secToggle;

  flash_toggle_status #(.NUM_SECT(NS), .SEC_AW(AW), .PROG_ABORT_TICKS(PT), .ERASE_ABORT_TICKS(ET))
  i_flash_toggle_status (
    .clk(clk), .rstN(rstN), .cmdSector(cmdSector), .progIssue(progIssue), .progDone(progDone),
    .eraseSelect(eraseSelect), .eraseBegin(eraseBegin), .eraseDone(eraseDone),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .sectorProt(sectorProt), .usTick(usTick),
    .readStrobe(readStrobe), .readSector(readSector), .rdValid(rdValid),
    .rdIsStatus(rdIsStatus), .devToggle(devToggle), .secToggle(secToggle)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] expQ[$];
  string tagQ[$];

  int mState = M_IDLE, mCnt = 0;
  logic mDev = 0, mSec = 0;
  logic [NS-1:0] mSel = '0;

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual{st,dev,sec}=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected result actual=%b expected=none", {rdIsStatus, devToggle, secToggle});
      end else begin
        chk(tagQ.pop_front(), {rdIsStatus, devToggle, secToggle}, expQ.pop_front());
      end
    end
  end

  task automatic rd(int s, string tag);
    logic hit, devAct, secElig, st;
    hit     = mSel[s];
    devAct  = (mState == M_PROG || mState == M_WAIT || mState == M_ERS ||
               mState == M_SPROG || mState == M_ABORT);
    secElig = (mState == M_WAIT || mState == M_ERS || mState == M_SUSP || mState == M_SPROG);
    if (devAct) mDev = ~mDev;
    if (secElig && hit) mSec = ~mSec;
    st = devAct || (mState == M_SUSP && hit);
    expQ.push_back({st, mDev, mSec});
    tagQ.push_back(tag);
    @(negedge clk);
    readStrobe = 1'b1; readSector = AW'(s);
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic cmd(int kind, int s);
    @(negedge clk);
    cmdSector = AW'(s);
    case (kind)
      K_PROG: begin
        progIssue = 1;
        if (mState == M_IDLE) begin
          mDev = 0; mSec = 0;
          if (sectorProt[s]) begin mState = M_ABORT; mCnt = PT; end
          else mState = M_PROG;
        end else if (mState == M_SUSP && !sectorProt[s]) mState = M_SPROG;
      end
      K_SEL: begin
        eraseSelect = 1;
        if (mState == M_IDLE) begin
          mDev = 0; mSec = 0; mSel = '0; mSel[s] = 1'b1; mState = M_WAIT;
        end else if (mState == M_WAIT) mSel[s] = 1'b1;
      end
      K_BEGIN: begin
        eraseBegin = 1;
        if (mState == M_WAIT) begin
          if ((mSel & ~sectorProt) == '0) begin mState = M_ABORT; mCnt = ET; mSel = '0; end
          else begin mSel = mSel & ~sectorProt; mState = M_ERS; end
        end
      end
      K_EDONE: begin
        eraseDone = 1;
        if (mState == M_ERS) begin mState = M_IDLE; mSel = '0; end
      end
      K_PDONE: begin
        progDone = 1;
        if (mState == M_PROG) mState = M_IDLE;
        else if (mState == M_SPROG) mState = M_SUSP;
      end
      K_SUSP: begin suspendReq = 1; if (mState == M_ERS) mState = M_SUSP; end
      K_RES:  begin resumeReq = 1;  if (mState == M_SUSP) mState = M_ERS; end
      default: begin
        usTick = 1;
        if (mState == M_ABORT) begin mCnt--; if (mCnt == 0) mState = M_IDLE; end
      end
    endcase
    @(negedge clk);
    progIssue = 0; eraseSelect = 0; eraseBegin = 0; eraseDone = 0;
    progDone = 0; suspendReq = 0; resumeReq = 0; usTick = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", {rdValid, devToggle, secToggle}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    rd(2, "R2 idle read");
    // plain program
    cmd(K_PROG, 2);
    rd(2, "R1 prog read a"); rd(5, "R1 prog read b"); rd(2, "R1 prog read c");
    cmd(K_PDONE, 0);
    rd(2, "R2 after prog a"); rd(4, "R2 after prog b");
    // erase with partial protection
    cmd(K_SEL, 3);
    chk("R9 start clears", {1'b0, devToggle, secToggle}, 3'b000);
    cmd(K_SEL, 5);
    rd(3, "R4 wait selected"); rd(1, "R4 wait unselected");
    cmd(K_SEL, 7);
    cmd(K_BEGIN, 0);
    rd(7, "R6 protected dropped"); rd(5, "R4 erasing selected");
    // suspend and program under suspend
    cmd(K_SUSP, 0);
    rd(3, "R3 suspended selected"); rd(3, "R4 suspended selected again");
    rd(2, "R4 suspended unselected");
    cmd(K_PROG, 0);
    rd(2, "R8 protected prog ignored");
    cmd(K_PROG, 2);
    rd(2, "R8 suspend prog a"); rd(3, "R8 suspend prog b");
    cmd(K_PDONE, 0);
    rd(3, "R8 back to suspend"); rd(1, "R8 back to suspend dev hold");
    cmd(K_RES, 0);
    rd(4, "R3 resumed a"); rd(5, "R3 resumed b");
    cmd(K_EDONE, 0);
    rd(3, "R2 after erase"); rd(3, "R2 after erase again");
    // selection emptied
    cmd(K_SEL, 4);
    rd(3, "R10 old sector cleared"); rd(4, "R10 new sector selected");
    cmd(K_BEGIN, 0);
    cmd(K_EDONE, 0);
    // all protected erase
    cmd(K_SEL, 0); cmd(K_SEL, 7);
    cmd(K_BEGIN, 0);
    rd(0, "R5 abort a"); rd(7, "R10 abort selection cleared");
    for (int k = 0; k < ET - 1; k++) cmd(K_TICK, 0);
    rd(3, "R5 abort last tick pending");
    cmd(K_TICK, 0);
    rd(3, "R5 abort over"); rd(0, "R5 abort over again");
    // protected program
    cmd(K_PROG, 7);
    rd(7, "R7 prog abort a"); rd(2, "R7 prog abort b");
    cmd(K_TICK, 0);
    rd(7, "R7 prog abort over");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 missing results actual=%0d expected=0", expQ.size());
    end
    summary();
  end
endmodule